// File: doc/BRIEF.md
# Sampling Converter Serial Slave

This block is the digital side of a sampling converter's serial port, built as a synthesizable slave. It runs on a system clock that is much faster than the serial clock. Chip select, serial clock and serial data in all pass through synchronizers. From these the block forms a gated internal serial clock and counts its edges within each conversion.

Each conversion takes sixteen internal falling edges. The block raises a track phase and then gives a one-cycle hold strobe that latches one of eight parallel 12-bit sample inputs. It shifts the result out MSB first behind four leading zeros. During the first half of the conversion it also takes in an 8-bit control byte. A 3-bit channel field in that byte picks the input for the next conversion.

The serial output is enabled only while the block is selected. Raising chip select in mid-conversion abandons the conversion.

Top module: `sampler_link`

## Requirements
- R1: `doutEn` is 0 after reset and whenever chip select (`csN`, active low) is high. It is 1 while chip select is low.
- R2: The internal serial clock is held high while deselected. If `sclk` is low when `csN` falls, that fall counts as internal falling edge 1. If `sclk` is high, edge 1 is the next real fall of `sclk`.
- R3: `trackOn` is 1 after internal falling edges 1 to 3 and drops at falling edge 4. At falling edge 4, `holdPulse` rises for exactly one system clock and the selected 12-bit sample is latched.
- R4: After internal falling edge k (k = 1..16) of a conversion, `dout` carries bit 15-k+1 of the word {4'b0000, sample[11:0]}. So edges 1 to 4 give zeros, and edges 5 to 16 give sample bits 11 down to 0.
- R5: A conversion ends at its sixteenth internal falling edge, where `doneStrobe` pulses for one system clock. While chip select stays low, the next falling edge is edge 1 of a new conversion.
- R6: `din` is shifted into the control register MSB first on rising edges 1 to 8 of each conversion. Values on rising edges 9 to 16 are ignored.
- R7: The control register resets to 0x00, which selects channel 0. The channel is control bits [5:3]; sample input c occupies `sampleBus[12c+11:12c]`, and the other control bits have no effect on the output. A byte loaded during one conversion is first used at the hold edge of the following conversion.
- R8: If chip select rises before rising edge 8 of a conversion, the partial control byte is discarded. Raising chip select also clears the edge counts, drops `trackOn`, and makes the next selection start a fresh conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than sclk |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select from the master, active low, asynchronous |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| din | input | 1 | Serial control data from the master |
| sampleBus | input | 96 | Eight 12-bit parallel sample words, channel c at bits 12c+11..12c |
| dout | output | 1 | Serial result bit, meaningful when doutEn is 1 |
| doutEn | output | 1 | Output enable of the dout pad; 0 means high impedance |
| trackOn | output | 1 | Track phase indication to the converter core |
| holdPulse | output | 1 | One-cycle strobe at the hold (sample) edge |
| doneStrobe | output | 1 | One-cycle strobe at the end of a conversion |

## Verification
The conversion path is exercised by frames of two back-to-back conversions. These frames alternate between serial clock idling high and idling low at selection, which separates correct gating from an off-by-one edge count. Every frame uses fresh sample words and channel bytes, and the bytes vary the non-channel bits. A wrong field decode, a missing one-conversion delay in applying the channel, or stray use of DIN after rising edge 8 each produce a different result word. Directed frames then abort after five rising edges, which must drop the byte, and after ten, which must keep it. A reset in mid-run must return channel selection to channel 0.

// File: rtl/sampler_link_pkg.sv
package sampler_link_pkg;

  // Strobes from the edge controller to the datapath, all single-cycle
  typedef struct packed {
    logic idle;        // deselected: clear serial state
    logic clearOut;    // falling edge within the leading-zero span
    logic loadSample;  // hold edge: latch selected channel
    logic shiftOut;    // falling edge within the data span
    logic shiftIn;     // rising edge within the control span
    logic commitCtrl;  // last control rising edge: load the register
  } dpStrobes_t;

endpackage

// File: rtl/sampler_link_sync.sv
module sampler_link_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/sampler_link_ctrl.sv
module sampler_link_ctrl
  import sampler_link_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int HOLD_EDGE = 4,
  parameter int LEAD_ZEROS = 4,
  parameter int CTRL_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sclkS,
  output dpStrobes_t st,
  output logic       trackOn,
  output logic       holdPulse,
  output logic       doneStrobe
);

  localparam int CNT_W = $clog2(FRAME_EDGES + 1);
  localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(FRAME_EDGES);
  localparam logic [CNT_W-1:0] EDGE_HOLD = CNT_W'(HOLD_EDGE);
  localparam logic [CNT_W-1:0] EDGE_ZERO = CNT_W'(LEAD_ZEROS);
  localparam logic [CNT_W-1:0] CTRL_EDGES = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             intClk, intPrev;
  logic             fallEv, riseEv;
  logic [CNT_W-1:0] fallCnt, riseCnt, nextFall;
  logic             newConv, ctrlRise;

  // Gated serial clock: forced high while deselected
  assign intClk = csS | sclkS;
  assign fallEv = intPrev & ~intClk;
  assign riseEv = ~intPrev & intClk & ~csS;

  assign newConv  = (fallCnt == '0) || (fallCnt == EDGE_LAST);
  assign nextFall = newConv ? ONE : fallCnt + ONE;
  assign ctrlRise = riseEv && (fallCnt != '0) && (riseCnt < CTRL_EDGES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intPrev <= 1'b1;
      fallCnt <= '0;
      riseCnt <= '0;
    end else begin
      intPrev <= intClk;
      if (csS) begin
        fallCnt <= '0;
        riseCnt <= '0;
      end else if (fallEv) begin
        fallCnt <= nextFall;
        if (newConv) riseCnt <= '0;
      end else if (riseEv && fallCnt != '0 && riseCnt < EDGE_LAST) begin
        riseCnt <= riseCnt + ONE;
      end
    end
  end

  always_comb begin
    st = '0;
    st.idle       = csS;
    st.clearOut   = fallEv && (nextFall <= EDGE_ZERO);
    st.shiftOut   = fallEv && (nextFall > EDGE_ZERO);
    st.loadSample = fallEv && (nextFall == EDGE_HOLD);
    st.shiftIn    = ctrlRise;
    st.commitCtrl = ctrlRise && (riseCnt == CTRL_EDGES - ONE);
  end

  assign trackOn = ~csS && (fallCnt != '0) && (fallCnt < EDGE_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdPulse  <= 1'b0;
      doneStrobe <= 1'b0;
    end else begin
      holdPulse  <= st.loadSample;
      doneStrobe <= fallEv && (nextFall == EDGE_LAST);
    end
  end

  AST_HOLD_ENDS_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    holdPulse |-> ($past(trackOn) && !trackOn)); // R3
  AST_DONE_AT_LAST_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (fallCnt == EDGE_LAST)); // R5
  AST_RISE_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    riseCnt <= fallCnt); // R6
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (fallCnt == '0 && riseCnt == '0)); // R8

endmodule

// File: rtl/sampler_link_dp.sv
module sampler_link_dp
  import sampler_link_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CH_NUM = 8,
  parameter int CTRL_W = 8,
  parameter int CH_LSB = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobes_t                 st,
  input  logic                       dinS,
  input  logic [CH_NUM*SAMPLE_W-1:0] sampleBus,
  output logic                       doutBit
);

  localparam int CH_W = $clog2(CH_NUM);

  logic [SAMPLE_W-1:0] chanWord [CH_NUM];
  logic [CTRL_W-2:0]   dinShift;
  logic [CTRL_W-1:0]   ctrlReg;
  logic [SAMPLE_W-1:0] holdReg;
  logic [CH_W-1:0]     chSel;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
    assign chanWord[c] = sampleBus[c*SAMPLE_W +: SAMPLE_W];
  end

  assign chSel = ctrlReg[CH_LSB +: CH_W];

  // Control byte intake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dinShift <= '0;
      ctrlReg  <= '0;
    end else if (st.idle) begin
      dinShift <= '0;
    end else if (st.shiftIn) begin
      dinShift <= {dinShift[CTRL_W-3:0], dinS};
      if (st.commitCtrl) ctrlReg <= {dinShift, dinS};
    end
  end

  // Result latch and serializer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      doutBit <= 1'b0;
    end else if (st.idle) begin
      doutBit <= 1'b0;
    end else begin
      if (st.loadSample) begin
        holdReg <= chanWord[chSel];
      end else if (st.shiftOut) begin
        holdReg <= {holdReg[SAMPLE_W-2:0], 1'b0};
      end
      if (st.clearOut) begin
        doutBit <= 1'b0;
      end else if (st.shiftOut) begin
        doutBit <= holdReg[SAMPLE_W-1];
      end
    end
  end

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !st.commitCtrl |=> $stable(ctrlReg)); // R7
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    st.clearOut |=> !doutBit); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    st.idle |=> (!doutBit && dinShift == '0)); // R8

endmodule

// File: rtl/sampler_link.sv
module sampler_link
  import sampler_link_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CH_NUM = 8,
  parameter int CTRL_W = 8,
  parameter int CH_LSB = 3,
  parameter int FRAME_EDGES = 16,
  parameter int HOLD_EDGE = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       din,
  input  logic [CH_NUM*SAMPLE_W-1:0] sampleBus,
  output logic                       dout,
  output logic                       doutEn,
  output logic                       trackOn,
  output logic                       holdPulse,
  output logic                       doneStrobe
);

  localparam int LEAD_ZEROS = FRAME_EDGES - SAMPLE_W;

  logic       csS, sclkS, dinS;
  dpStrobes_t st;

  sampler_link_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({csN, sclk, din}),
    .syncOut({csS, sclkS, dinS})
  );

  sampler_link_ctrl #(
    .FRAME_EDGES(FRAME_EDGES), .HOLD_EDGE(HOLD_EDGE),
    .LEAD_ZEROS(LEAD_ZEROS), .CTRL_W(CTRL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .sclkS(sclkS),
    .st(st), .trackOn(trackOn), .holdPulse(holdPulse), .doneStrobe(doneStrobe)
  );

  sampler_link_dp #(
    .SAMPLE_W(SAMPLE_W), .CH_NUM(CH_NUM), .CTRL_W(CTRL_W), .CH_LSB(CH_LSB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .dinS(dinS),
    .sampleBus(sampleBus), .doutBit(dout)
  );

  assign doutEn = ~csS;

endmodule

// File: tb/sampler_link_tb.sv
module sampler_link_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NVEC = 5;
  // {idleLow, byte for conversion 0, byte for conversion 1}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'hAD, 8'h13},
    {1'b1, 8'h3F, 8'hC0},
    {1'b0, 8'h0A, 8'h71},
    {1'b1, 8'h18, 8'hA7},
    {1'b0, 8'hA0, 8'h27}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [95:0] sampleBus = '0;
  logic        dout, doutEn, trackOn, holdPulse, doneStrobe;

  int nChecks = 0;
  int nFails = 0;
  int holdCnt = 0;
  int doneCnt = 0;
  int expCh = 0;
  bit finished = 1'b0;

  sampler_link u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .sampleBus(sampleBus), .dout(dout), .doutEn(doutEn),
    .trackOn(trackOn), .holdPulse(holdPulse), .doneStrobe(doneStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (holdPulse) holdCnt <= holdCnt + 1;
    if (doneStrobe) doneCnt <= doneCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] sampVal(input int ch, input int seed);
    return 12'(12'hA5C ^ (ch * 273) ^ (seed * 97));
  endfunction

  task automatic loadSamples(input int seed);
    for (int c = 0; c < 8; c++) sampleBus[c*12 +: 12] = sampVal(c, seed);
  endtask

  // One selection of nCyc serial cycles; two conversions at most
  task automatic runFrame(input bit idleLow, input int nCyc,
                          input logic [7:0] b0, input logic [7:0] b1, input int seed);
    logic [15:0] cap;
    logic [7:0]  cur;
    int h0, d0, convCh, partial;
    cap = '0;
    convCh = expCh;
    loadSamples(seed);
    csN = 1'b1;
    sclk = !idleLow;
    waitClk(HALF);
    h0 = holdCnt;
    d0 = doneCnt;
    if (!idleLow) begin
      csN = 1'b0;
      waitClk(HALF);
    end
    for (int i = 0; i < nCyc; i++) begin
      int ph;
      ph = i % 16;
      cur = (i < 16) ? b0 : b1;
      if (idleLow && i == 0) csN = 1'b0;
      else sclk = 1'b0;
      din = (ph < 8) ? cur[7-ph] : ~cur[ph-8];
      waitClk(HALF);
      check(doutEn == 1'b1, "R1 enable while selected", doutEn, 1);
      check(trackOn == (ph < 3), "R3 track phase", trackOn, (ph < 3));
      cap[15-ph] = dout;
      if (ph == 3) convCh = expCh;
      sclk = 1'b1;
      waitClk(HALF);
      if (ph == 7) expCh = cur[5:3];
      if (ph == 15)
        check(cap == {4'b0000, sampVal(convCh, seed)},
              idleLow ? "R2 R4 R6 R7 word, sclk idle low" : "R4 R6 R7 word, sclk idle high",
              cap, {4'b0000, sampVal(convCh, seed)});
    end
    csN = 1'b1;
    waitClk(HALF);
    if (idleLow) sclk = 1'b0;
    partial = nCyc % 16;
    check(doutEn == 1'b0, "R1 disable when deselected", doutEn, 0);
    check(trackOn == 1'b0, "R8 no track after deselect", trackOn, 0);
    check(holdCnt - h0 == nCyc / 16 + (partial >= 4 ? 1 : 0), "R3 hold strobes",
          holdCnt - h0, nCyc / 16 + (partial >= 4 ? 1 : 0));
    check(doneCnt - d0 == nCyc / 16, "R5 done strobes", doneCnt - d0, nCyc / 16);
  endtask

  initial begin
    waitClk(3);
    check(doutEn == 1'b0, "R1 reset enable", doutEn, 0);
    check(trackOn == 1'b0 && holdPulse == 1'b0, "R3 reset idle", trackOn, 0);
    rstN = 1'b1;
    waitClk(4);

    for (int v = 0; v < NVEC; v++) begin
      runFrame(VEC[v][16], 32, VEC[v][15:8], VEC[v][7:0], v + 1);
    end

    // R8: abort after 5 rising edges drops the byte (expCh stays 4)
    runFrame(1'b0, 5, 8'hFF, 8'h00, 11);
    check(expCh == 4, "R8 bench model", expCh, 4);
    runFrame(1'b1, 32, 8'h08, 8'h30, 12);
    // R8: abort after 10 rising edges keeps the complete byte
    runFrame(1'b0, 10, 8'h10, 8'h00, 13);
    runFrame(1'b0, 32, 8'h28, 8'h38, 14);

    // R7: reset returns the channel to 0
    rstN = 1'b0;
    waitClk(3);
    check(doutEn == 1'b0, "R1 enable under reset", doutEn, 0);
    rstN = 1'b1;
    expCh = 0;
    waitClk(4);
    runFrame(1'b1, 32, 8'h20, 8'h00, 15);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule